// File: doc/BRIEF.md
# Typed-Access Control Register File

This block is the control and status register space of a network controller. It decodes a 16-bit byte offset into a small set of 32-bit registers. Each register has one of six access types: read-only, read-write, write-only, read-to-clear, write-one-to-set and write-one-to-clear. The type decides what a read returns, what a write stores and whether a read changes the register. Writes are limited by a per-register bit mask, and every register returns to a fixed value on reset.

Software drives a plain request port: an offset, a write strobe with data and a read strobe. Read data comes back one cycle later together with a valid flag. Every write to a mapped offset produces a one-cycle event that carries the offset, the value before the write and the value after it. A write that sets bit 0 of the control register also produces a one-cycle soft-reset pulse. Hardware raises interrupt causes through a set vector, and reading the cause register clears it.

Top module: `nicreg_file`

## Requirements
- R1: After reset, a read returns these values one cycle later with `rd_valid` high: control (0x0000) 0, status (0x0004) 0x00000003, mask-set (0x0014) 0, flag register (0x001C) 0x000000FF.
- R2: The status register is read-only. A write of 0xFFFFFFFF leaves it at 0x00000003.
- R3: Read-write registers store the written bits that their write mask allows. The control register (0x0000) has mask 0xFFFFFFFF. The counter register (0x0100) has mask 0x00FFFFFF, so writing 0xFFFFFFFF to it reads back 0x00FFFFFF.
- R4: The scratch register (0x0018) is write-only. It always reads 0, but it stores the written value, which the next write event to it shows as the old value.
- R5: The cause register (0x0010) is read-to-clear. A read returns its value and then clears it to 0. Writes to it have no effect. A bit in `cause_set` sets the matching cause bit.
- R6: On the mask-set register (0x0014), each written 1 sets the matching bit and each written 0 leaves that bit unchanged. Writing 0x3 and then 0x4 reads back 0x7.
- R7: On the flag register (0x001C, mask 0x000000FF), each written 1 clears the matching bit, and written 0s have no effect. Bits outside the mask are never changed.
- R8: Each write to a mapped offset gives exactly one `evt_valid` cycle, on the cycle after the write. It carries the offset, the old value and the value the write produced.
- R9: A write to the control register with bit 0 set gives a one-cycle `soft_rst` pulse in the same cycle as its write event.
- R10: A read from an unmapped offset returns 0. A write to an unmapped offset changes nothing and gives no event.
- R11: If a cause bit is set in the same cycle that the cause register is read, the read returns the old value and the newly set bit stays in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | 16 | Byte offset of the access |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 32 | Write data |
| req_rd | input | 1 | Read strobe |
| cause_set | input | 32 | Hardware set bits for the cause register |
| rd_data | output | 32 | Read data, one cycle after `req_rd` |
| rd_valid | output | 1 | Marks `rd_data` valid |
| evt_valid | output | 1 | One-cycle write event |
| evt_offs | output | 16 | Offset of the write |
| evt_old | output | 32 | Register value before the write |
| evt_new | output | 32 | Register value produced by the write |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
The assertions assume that a read and a write are never issued in the same cycle. They also assume that `cause_set` is quiet whenever the cause register is written, so the `evt_new` of that write shows only the write's own effect. The stimulus issues one access per call, drives `cause_set` only next to cause reads or on idle cycles, and places the same-cycle collision between a set and a read on purpose.

// File: rtl/nicreg_pkg.sv
// Package: shared widths, access-type encoding and the register table.
// Assumes a small fixed register count. Table entries are computed by index.
package nicreg_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int NUM_REGS  = 7;
    localparam int CTRL_IDX  = 0;
    localparam int CAUSE_IDX = 2;

    typedef enum logic [2:0] {
        ACC_RO,
        ACC_RW,
        ACC_WO,
        ACC_RC,
        ACC_RW1C,
        ACC_RW1S
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] offs;
        acc_e              acc;
        logic [DATA_W-1:0] rst_val;
        logic [DATA_W-1:0] wmask;
    } reg_desc_t;

    // Register table lookup by slot index
    function automatic reg_desc_t reg_desc(input int idx);
        reg_desc_t d;
        case (idx)
            0:       d = '{16'h0000, ACC_RW,   32'h0000_0000, 32'hFFFF_FFFF};
            1:       d = '{16'h0004, ACC_RO,   32'h0000_0003, 32'h0000_0000};
            2:       d = '{16'h0010, ACC_RC,   32'h0000_0000, 32'h0000_0000};
            3:       d = '{16'h0014, ACC_RW1S, 32'h0000_0000, 32'hFFFF_FFFF};
            4:       d = '{16'h0018, ACC_WO,   32'h0000_0000, 32'hFFFF_FFFF};
            5:       d = '{16'h001C, ACC_RW1C, 32'h0000_00FF, 32'h0000_00FF};
            default: d = '{16'h0100, ACC_RW,   32'h0000_0000, 32'h00FF_FFFF};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nicreg_decode.sv
// Offset decoder: compares the request offset with every table entry.
// Assumes the table offsets are distinct, so sel is one-hot or all-zero.
module nicreg_decode
    import nicreg_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);

    // One comparator per register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
        localparam reg_desc_t D = reg_desc(i);
        assign sel[i] = (addr == D.offs);
    end

    // Any match means the offset is mapped
    assign hit = |sel;

endmodule

// File: rtl/nicreg_slot.sv
// One register with a fixed access type.
// Computes the value a write would produce and updates the stored value on
// writes, on read-to-clear reads and on hardware sets.
// Assumes rd_en and wr_en are never high together.
module nicreg_slot
    import nicreg_pkg::*;
#(
    parameter acc_e              ACC     = ACC_RW,
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter logic [DATA_W-1:0] WMASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] wr_result
);

    logic [DATA_W-1:0] wbits;
    assign wbits = wdata & WMASK;

    // Value the register would hold after a write, by access type
    always_comb begin
        case (ACC)
            ACC_RW, ACC_WO: wr_result = (value & ~WMASK) | wbits;
            ACC_RW1S:       wr_result = value | wbits;
            ACC_RW1C:       wr_result = value & ~wbits;
            default:        wr_result = value;
        endcase
    end

    // State update: reset, clear on read, write, then hardware set on top
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (ACC == ACC_RC && rd_en)
            value <= hw_set;
        else if (wr_en)
            value <= wr_result | hw_set;
        else
            value <= value | hw_set;
    end

    if (ACC == ACC_RO) begin : g_ro_chk
        // R2
        ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> $stable(value));
    end
    if (ACC == ACC_RC) begin : g_rc_chk
        // R5 R11
        rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> value == $past(hw_set));
    end
    if (ACC == ACC_RW1S) begin : g_w1s_chk
        // R6
        w1s_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(value) & ~value) == '0));
    end
    if (ACC == ACC_RW1C) begin : g_w1c_chk
        // R7
        w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((value & ~$past(value)) == '0));
    end

endmodule

// File: rtl/nicreg_file.sv
// Top of the register file: decodes the request and runs one slot per table
// entry. Registers the read data, the write event and the soft-reset pulse.
// Assumes one access per cycle (req_rd and req_wr not high together).
module nicreg_file
    import nicreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_rd,
    input  logic [DATA_W-1:0] cause_set,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              evt_valid,
    output logic [ADDR_W-1:0] evt_offs,
    output logic [DATA_W-1:0] evt_old,
    output logic [DATA_W-1:0] evt_new,
    output logic              soft_rst
);

    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [DATA_W-1:0]   value   [NUM_REGS];
    logic [DATA_W-1:0]   wr_res  [NUM_REGS];
    logic [DATA_W-1:0]   rd_view [NUM_REGS];
    logic [DATA_W-1:0]   rd_mux, old_mux, new_mux;

    nicreg_decode u_decode (
        .addr (req_addr),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam reg_desc_t D = reg_desc(i);
        logic [DATA_W-1:0] hw_in;
        assign hw_in = (i == CAUSE_IDX) ? cause_set : '0;

        nicreg_slot #(
            .ACC     (D.acc),
            .RST_VAL (D.rst_val),
            .WMASK   (D.wmask)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (req_wr & sel[i]),
            .rd_en     (req_rd & sel[i]),
            .wdata     (req_wdata),
            .hw_set    (hw_in),
            .value     (value[i]),
            .wr_result (wr_res[i])
        );

        // Write-only registers hide their contents from reads
        assign rd_view[i] = (D.acc == ACC_WO) ? '0 : value[i];
    end

    // Select read data and event values of the addressed slot
    always_comb begin
        rd_mux  = '0;
        old_mux = '0;
        new_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                rd_mux  = rd_mux  | rd_view[i];
                old_mux = old_mux | value[i];
                new_mux = new_mux | wr_res[i];
            end
        end
    end

    // Register the read response, the write event and the soft-reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            evt_valid <= 1'b0;
            evt_offs  <= '0;
            evt_old   <= '0;
            evt_new   <= '0;
            soft_rst  <= 1'b0;
        end else begin
            rd_valid  <= req_rd;
            rd_data   <= req_rd ? rd_mux : '0;
            evt_valid <= req_wr & hit;
            evt_offs  <= req_addr;
            evt_old   <= old_mux;
            evt_new   <= new_mux;
            soft_rst  <= req_wr & sel[CTRL_IDX] & req_wdata[0];
        end
    end

    // R8
    evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |=> !evt_valid);
    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !hit) |=> !evt_valid);
    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !hit) |=> (rd_valid && rd_data == '0));
    // R9
    srst_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (evt_valid && evt_offs == '0 && evt_new[0]));
    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> !rd_valid);

endmodule

// File: tb/nicreg_file_bench.sv
// Scoreboard bench: driver tasks queue the expected reads and events, and a
// monitor pops and compares them as the design produces them.
module nicreg_file_bench;

    typedef struct {
        logic [31:0] d;
        string       r;
    } rd_exp_t;

    typedef struct {
        logic [15:0] a;
        logic [31:0] o;
        logic [31:0] n;
        string       r;
    } evt_exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_rd = 1'b0;
    logic [31:0] cause_set = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        evt_valid;
    logic [15:0] evt_offs;
    logic [31:0] evt_old;
    logic [31:0] evt_new;
    logic        soft_rst;

    int errs = 0;
    int checks = 0;
    int srst_cnt = 0;
    rd_exp_t  rd_q[$];
    evt_exp_t evt_q[$];

    always #5 clk = ~clk;

    nicreg_file u_nicreg_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .req_rd    (req_rd),
        .cause_set (cause_set),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .evt_valid (evt_valid),
        .evt_offs  (evt_offs),
        .evt_old   (evt_old),
        .evt_new   (evt_new),
        .soft_rst  (soft_rst)
    );

    // Monitor: compare responses against the queued expectations
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                checks++;
                if (rd_q.size() == 0) begin
                    errs++;
                    $display("FAIL R1 unexpected read data %h, expected none", rd_data);
                end else begin
                    rd_exp_t e;
                    e = rd_q.pop_front();
                    if (rd_data !== e.d) begin
                        errs++;
                        $display("FAIL %s read got %h expected %h", e.r, rd_data, e.d);
                    end
                end
            end
            if (evt_valid) begin
                checks++;
                if (evt_q.size() == 0) begin
                    errs++;
                    $display("FAIL R8/R10 unexpected event %h %h %h, expected none",
                             evt_offs, evt_old, evt_new);
                end else begin
                    evt_exp_t e;
                    e = evt_q.pop_front();
                    if (evt_offs !== e.a || evt_old !== e.o || evt_new !== e.n) begin
                        errs++;
                        $display("FAIL %s event got %h/%h/%h expected %h/%h/%h", e.r,
                                 evt_offs, evt_old, evt_new, e.a, e.o, e.n);
                    end
                end
            end
            if (soft_rst) srst_cnt++;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic ev,
                      input logic [31:0] eo, input logic [31:0] en, input string r);
        if (ev) evt_q.push_back('{a, eo, en, r});
        @(negedge clk);
        req_addr = a; req_wdata = d; req_wr = 1'b1;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp_d, input string r);
        rd_q.push_back('{exp_d, r});
        @(negedge clk);
        req_addr = a; req_rd = 1'b1;
        @(negedge clk);
        req_rd = 1'b0;
    endtask

    task automatic pulse_cause(input logic [31:0] v);
        @(negedge clk);
        cause_set = v;
        @(negedge clk);
        cause_set = '0;
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(16'h0000, 32'h0, "R1");
        rd(16'h0004, 32'h3, "R1");
        rd(16'h0014, 32'h0, "R1");
        rd(16'h001C, 32'hFF, "R1");
        // R2 read-only status
        wr(16'h0004, 32'hFFFF_FFFF, 1, 32'h3, 32'h3, "R2");
        rd(16'h0004, 32'h3, "R2");
        // R3 read-write with mask, R9 soft reset
        wr(16'h0000, 32'h1234_5678, 1, 32'h0, 32'h1234_5678, "R3");
        rd(16'h0000, 32'h1234_5678, "R3");
        wr(16'h0000, 32'h0000_0001, 1, 32'h1234_5678, 32'h1, "R9");
        wr(16'h0100, 32'hFFFF_FFFF, 1, 32'h0, 32'h00FF_FFFF, "R3");
        rd(16'h0100, 32'h00FF_FFFF, "R3");
        // R4 write-only scratch
        wr(16'h0018, 32'hCAFE_F00D, 1, 32'h0, 32'hCAFE_F00D, "R4");
        rd(16'h0018, 32'h0, "R4");
        wr(16'h0018, 32'h0000_0001, 1, 32'hCAFE_F00D, 32'h1, "R4");
        // R6 write-one-to-set
        wr(16'h0014, 32'h3, 1, 32'h0, 32'h3, "R6");
        wr(16'h0014, 32'h4, 1, 32'h3, 32'h7, "R6");
        rd(16'h0014, 32'h7, "R6");
        // R7 write-one-to-clear
        wr(16'h001C, 32'h0F, 1, 32'hFF, 32'hF0, "R7");
        rd(16'h001C, 32'hF0, "R7");
        wr(16'h001C, 32'hF00, 1, 32'hF0, 32'hF0, "R7");
        rd(16'h001C, 32'hF0, "R7");
        // R5 read-to-clear cause
        pulse_cause(32'h5);
        rd(16'h0010, 32'h5, "R5");
        rd(16'h0010, 32'h0, "R5");
        pulse_cause(32'h1);
        wr(16'h0010, 32'hFFFF, 1, 32'h1, 32'h1, "R5");
        rd(16'h0010, 32'h1, "R5");
        rd(16'h0010, 32'h0, "R5");
        // R11 set in the same cycle as a clearing read
        pulse_cause(32'h8);
        rd_q.push_back('{32'h8, "R11"});
        @(negedge clk);
        req_addr = 16'h0010; req_rd = 1'b1; cause_set = 32'h2;
        @(negedge clk);
        req_rd = 1'b0; cause_set = '0;
        rd(16'h0010, 32'h2, "R11");
        rd(16'h0010, 32'h0, "R11");
        // R10 unmapped offsets
        wr(16'h0040, 32'hFFFF_FFFF, 0, 32'h0, 32'h0, "R10");
        rd(16'h0040, 32'h0, "R10");
        rd(16'h0008, 32'h0, "R10");
        wr(16'h0102, 32'h1, 0, 32'h0, 32'h0, "R10");
        rd(16'h0000, 32'h1, "R10");
        repeat (4) @(negedge clk);
        // R8 all expected events and reads seen
        checks++;
        if (evt_q.size() != 0) begin
            errs++;
            $display("FAIL R8 %0d events missing, expected 0", evt_q.size());
        end
        checks++;
        if (rd_q.size() != 0) begin
            errs++;
            $display("FAIL R1 %0d reads missing, expected 0", rd_q.size());
        end
        // R9 exactly one single-cycle pulse
        checks++;
        if (srst_cnt != 1) begin
            errs++;
            $display("FAIL R9 soft reset cycles %0d expected 1", srst_cnt);
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errs++;
                $display("FAIL watchdog expired, got hang expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule